// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This block erases one flash block without leaving cells stuck at one. A single `start` strobe begins the run. The sequencer first asks a word programming sequencer to write zero to every word of the block, in ascending address order. This evens out the stored charge across the block. After that it checks the supply, arms the flash control register for a block erase, and issues erase pulses. Each pulse acts on the whole block.

After every pulse it reads the array to confirm that each word has reached all ones. Every address is read twice with a settling gap between the two reads, and only the second read is compared. When a word still holds a zero bit, the sequencer applies another block pulse and continues from that same word. It does not go back to the start of the block. The pulse budget is shared by the whole block. At the end the control register is disarmed, and `done` rises together with at most one failure flag.

States: IDLE, PRE_REQ (ask for a zero write), PRE_WAIT (wait for program done), SUPPLY (check the supply before the first pulse), ARM (write the erase configuration), PULSE (issue the erase command), BUSY (wait until the engine busy clears, then check the glitch flag), RD_FIRST (first verify read), GAP (settling wait), RD_SECOND (second read and compare), DISARM (clear the control register). The transitions are:

- IDLE→PRE_REQ on start.
- PRE_REQ→PRE_WAIT.
- PRE_WAIT→PRE_REQ on the next word, →SUPPLY after the last word, →IDLE on a program failure.
- SUPPLY→ARM when the supply is good, →IDLE when it is low.
- ARM→PULSE.
- PULSE→BUSY.
- BUSY→RD_FIRST on a clean end of pulse, →DISARM on a glitch.
- RD_FIRST→GAP.
- GAP→RD_SECOND.
- RD_SECOND→RD_FIRST on the next address, →PULSE on a mismatch while budget remains, →DISARM when the block passes or the budget is spent.
- DISARM→IDLE.

Top module: `block_erase_seq`

## Requirements
- R1: Before any control-register write or erase command, `pgm_start` is issued once per word, at addresses BLK_START, BLK_START+2, … up to BLK_START+BLK_BYTES-2, in that order.
- R2: If `pgm_fail` is high with `pgm_done`, the run ends with `prog_fail`; no further program request, control write or erase command follows.
- R3: After pre-programming, `supply_ok` low ends the run with `supply_fail`; there is no control write and no erase command.
- R4: The first erase command is preceded by exactly one control write with `ctl_arm`=1, and `erase_go` is only issued while the register is armed.
- R5: A pulse ends when `eng_busy` (high from the cycle after `erase_go`) is low. If `eng_glitch` is high at that point, the run ends with `supply_fail` after a disarm write.
- R6: Each verified address is read twice with no other address in between. The second read starts at least GAP+1 cycles after the first, and only the second read is compared against all ones.
- R7: On a mismatch, a new block pulse is issued, and verification resumes at the failing address rather than at the block start.
- R8: Verify addresses step by 2 within the block. When the last word reads all ones, one control write with `ctl_arm`=0 follows and the run ends with `done` and no failure flag.
- R9: At most MAX_PULSES erase commands are issued per run. A mismatch after the last allowed pulse ends the run with `erase_fail` after a disarm write. Exactly MAX_PULSES pulses that do clear the block still succeed.
- R10: `done` and at most one failure flag stay high until the next accepted `start`; a `start` during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a block erase (accepted in IDLE) |
| supply_ok | input | 1 | High-voltage supply present |
| ctl_wr | output | 1 | Control-register write strobe |
| ctl_arm | output | 1 | Value written: 1 arms block erase, 0 clears |
| erase_go | output | 1 | Erase command strobe, one cycle |
| eng_busy | input | 1 | Erase pulse in progress |
| eng_glitch | input | 1 | Supply dropped during the last pulse |
| pgm_start | output | 1 | Request a zero write at `pgm_addr` |
| pgm_addr | output | ADDR_W | Byte address of the word to zero |
| pgm_done | input | 1 | Program sequencer finished |
| pgm_fail | input | 1 | Program sequencer gave up (valid with done) |
| rd_en | output | 1 | Array read strobe |
| rd_addr | output | ADDR_W | Array read byte address |
| rd_data | input | DATA_W | Array read data, same cycle |
| done | output | 1 | Run finished |
| prog_fail | output | 1 | Pre-program phase failed |
| erase_fail | output | 1 | Pulse budget exhausted |
| supply_fail | output | 1 | Supply low before erase or glitch during a pulse |

## Verification
Two decisions can fall on the same cycle. One is a verify mismatch on the last word. The other is the pulse budget running out. In that cycle the sequencer has to choose between issuing another pulse and failing, and it has to keep the verify position. The bench provokes this with a word that needs exactly the budget, which must succeed. It then uses a word that needs more than the budget, which must fail after exactly MAX_PULSES commands. A third case puts a glitch on the end of the only pulse, in the same cycle the first verify read would begin. The bench judges all three by counting erase commands, control writes, the last written arm value, and which flag stands with `done`.

// File: rtl/bes_pkg.sv
package bes_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE_REQ,
        ST_PRE_WAIT,
        ST_SUPPLY,
        ST_ARM,
        ST_PULSE,
        ST_BUSY,
        ST_RD_FIRST,
        ST_GAP,
        ST_RD_SECOND,
        ST_DISARM
    } seq_state_t;

    typedef enum logic [2:0] {
        RES_NONE,
        RES_OK,
        RES_PGM,
        RES_ERS,
        RES_SUP
    } seq_result_t;
endpackage

// File: rtl/bes_addr_walk.sv
module bes_addr_walk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned FIRST  = 'h3000,
    parameter int unsigned LAST   = 'h5FFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] FIRST_A = ADDR_W'(FIRST);
    localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'(LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr <= FIRST_A;
        else if (load)
            addr <= FIRST_A;
        else if (step)
            addr <= addr + ADDR_W'(2);
    end

    assign last = (addr == LAST_A);
endmodule

// File: rtl/bes_pulse_cnt.sv
module bes_pulse_cnt #(
    parameter int unsigned MAX_PULSES = 18315
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_max
);
    localparam int unsigned CW = $clog2(MAX_PULSES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (inc)
            cnt_q <= cnt_q + CW'(1);
    end

    assign at_max = (cnt_q == CW'(MAX_PULSES));
endmodule

// File: rtl/bes_gap_timer.sv
module bes_gap_timer #(
    parameter int unsigned GAP = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int unsigned TW = $clog2(GAP + 1);

    logic [TW-1:0] t_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            t_q <= '0;
        else if (load)
            t_q <= TW'(GAP);
        else if (t_q != '0)
            t_q <= t_q - TW'(1);
    end

    assign expired = (t_q == '0);
endmodule

// File: rtl/block_erase_seq.sv
module block_erase_seq
    import bes_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned BLK_START  = 'h3000,
    parameter int unsigned BLK_BYTES  = 'h3000,
    parameter int unsigned MAX_PULSES = 18315,
    parameter int unsigned GAP        = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              supply_ok,
    output logic              ctl_wr,
    output logic              ctl_arm,
    output logic              erase_go,
    input  logic              eng_busy,
    input  logic              eng_glitch,
    output logic              pgm_start,
    output logic [ADDR_W-1:0] pgm_addr,
    input  logic              pgm_done,
    input  logic              pgm_fail,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              prog_fail,
    output logic              erase_fail,
    output logic              supply_fail
);
    localparam int unsigned LAST_BYTE = BLK_START + BLK_BYTES - 2;

    seq_state_t  state_q, state_d;
    seq_result_t res_q, res_d;

    logic              addr_load, addr_step, addr_last;
    logic [ADDR_W-1:0] addr;
    logic              pc_clr, pc_inc, pc_max;
    logic              gap_load, gap_done;
    logic              word_erased;

    assign word_erased = &rd_data;

    bes_addr_walk #(.ADDR_W(ADDR_W), .FIRST(BLK_START), .LAST(LAST_BYTE)) u_walk (
        .clk(clk), .rst_n(rst_n), .load(addr_load), .step(addr_step),
        .addr(addr), .last(addr_last)
    );

    bes_pulse_cnt #(.MAX_PULSES(MAX_PULSES)) u_pcnt (
        .clk(clk), .rst_n(rst_n), .clr(pc_clr), .inc(pc_inc), .at_max(pc_max)
    );

    bes_gap_timer #(.GAP(GAP)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(gap_load), .expired(gap_done)
    );

    // Next state and sequencing controls
    always_comb begin
        state_d   = state_q;
        res_d     = res_q;
        addr_load = 1'b0;
        addr_step = 1'b0;
        pc_clr    = 1'b0;
        pc_inc    = 1'b0;
        gap_load  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d   = ST_PRE_REQ;
                    res_d     = RES_NONE;
                    addr_load = 1'b1;
                end
            end
            ST_PRE_REQ: state_d = ST_PRE_WAIT;
            ST_PRE_WAIT: begin
                if (pgm_done) begin
                    if (pgm_fail) begin
                        state_d = ST_IDLE;
                        res_d   = RES_PGM;
                    end else if (addr_last) begin
                        state_d = ST_SUPPLY;
                    end else begin
                        state_d   = ST_PRE_REQ;
                        addr_step = 1'b1;
                    end
                end
            end
            ST_SUPPLY: begin
                if (supply_ok) begin
                    state_d   = ST_ARM;
                    addr_load = 1'b1;
                    pc_clr    = 1'b1;
                end else begin
                    state_d = ST_IDLE;
                    res_d   = RES_SUP;
                end
            end
            ST_ARM: state_d = ST_PULSE;
            ST_PULSE: begin
                state_d = ST_BUSY;
                pc_inc  = 1'b1;
            end
            ST_BUSY: begin
                if (!eng_busy) begin
                    if (eng_glitch) begin
                        state_d = ST_DISARM;
                        res_d   = RES_SUP;
                    end else begin
                        state_d = ST_RD_FIRST;
                    end
                end
            end
            ST_RD_FIRST: begin
                state_d  = ST_GAP;
                gap_load = 1'b1;
            end
            ST_GAP: begin
                if (gap_done)
                    state_d = ST_RD_SECOND;
            end
            ST_RD_SECOND: begin
                if (word_erased) begin
                    if (addr_last) begin
                        state_d = ST_DISARM;
                        res_d   = RES_OK;
                    end else begin
                        state_d   = ST_RD_FIRST;
                        addr_step = 1'b1;
                    end
                end else if (pc_max) begin
                    state_d = ST_DISARM;
                    res_d   = RES_ERS;
                end else begin
                    state_d = ST_PULSE;
                end
            end
            ST_DISARM: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            res_q   <= RES_NONE;
        end else begin
            state_q <= state_d;
            res_q   <= res_d;
        end
    end

    // Outputs
    always_comb begin
        ctl_wr      = (state_q == ST_ARM) || (state_q == ST_DISARM);
        ctl_arm     = (state_q == ST_ARM);
        erase_go    = (state_q == ST_PULSE);
        pgm_start   = (state_q == ST_PRE_REQ);
        pgm_addr    = addr;
        rd_en       = (state_q == ST_RD_FIRST) || (state_q == ST_RD_SECOND);
        rd_addr     = addr;
        done        = (state_q == ST_IDLE) && (res_q != RES_NONE);
        prog_fail   = (state_q == ST_IDLE) && (res_q == RES_PGM);
        erase_fail  = (state_q == ST_IDLE) && (res_q == RES_ERS);
        supply_fail = (state_q == ST_IDLE) && (res_q == RES_SUP);
    end
endmodule

// File: rtl/block_erase_seq_chk.sv
module block_erase_seq_chk #(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned BLK_START  = 'h3000,
    parameter int unsigned BLK_BYTES  = 'h3000,
    parameter int unsigned MAX_PULSES = 18315
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              ctl_wr,
    input logic              ctl_arm,
    input logic              erase_go,
    input logic              eng_busy,
    input logic              pgm_start,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              done,
    input logic              prog_fail,
    input logic              erase_fail,
    input logic              supply_fail
);
    localparam int unsigned WORDS = BLK_BYTES / 2;
    localparam int unsigned LAST  = BLK_START + BLK_BYTES - 2;

    logic run_q, done_q, armed_q;
    int unsigned pgm_n, go_n;
    logic accept;

    assign accept = start && !run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            done_q  <= 1'b0;
            armed_q <= 1'b0;
            pgm_n   <= 0;
            go_n    <= 0;
        end else begin
            done_q <= done;
            if (accept)
                run_q <= 1'b1;
            else if (done && !done_q)
                run_q <= 1'b0;
            if (ctl_wr)
                armed_q <= ctl_arm;
            if (accept)
                pgm_n <= 0;
            else if (pgm_start)
                pgm_n <= pgm_n + 1;
            if (accept)
                go_n <= 0;
            else if (erase_go)
                go_n <= go_n + 1;
        end
    end

    assert_preprog_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |-> pgm_n == WORDS);

    assert_arm_after_preprog_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_arm) |-> pgm_n == WORDS);

    assert_go_while_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |-> armed_q);

    assert_go_engine_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |-> !eng_busy);

    assert_pulse_budget_R9: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |-> go_n < MAX_PULSES);

    assert_read_in_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_addr >= ADDR_W'(BLK_START)) && (rd_addr <= ADDR_W'(LAST)) && !rd_addr[0]);

    assert_single_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_fail, erase_fail, supply_fail}));

    assert_flag_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_fail || erase_fail || supply_fail) |-> done);
endmodule

bind block_erase_seq block_erase_seq_chk #(
    .ADDR_W(ADDR_W), .BLK_START(BLK_START), .BLK_BYTES(BLK_BYTES), .MAX_PULSES(MAX_PULSES)
) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ctl_wr(ctl_wr), .ctl_arm(ctl_arm),
    .erase_go(erase_go), .eng_busy(eng_busy), .pgm_start(pgm_start), .rd_en(rd_en),
    .rd_addr(rd_addr), .done(done), .prog_fail(prog_fail), .erase_fail(erase_fail),
    .supply_fail(supply_fail)
);

// File: tb/block_erase_seq_tb_top.sv
module block_erase_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int START = 'h0040;
    localparam int BYTES = 16;
    localparam int NW = BYTES / 2;
    localparam int MAXP = 3;
    localparam int GAPC = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic supply_ok = 1'b1;
    logic ctl_wr, ctl_arm, erase_go, pgm_start, rd_en;
    logic eng_busy, eng_glitch, pgm_done, pgm_fail;
    logic [AW-1:0] pgm_addr, rd_addr;
    logic [DW-1:0] rd_data;
    logic done, prog_fail, erase_fail, supply_fail;

    always #(CLK_PERIOD/2) clk = ~clk;

    block_erase_seq #(
        .ADDR_W(AW), .DATA_W(DW), .BLK_START(START), .BLK_BYTES(BYTES),
        .MAX_PULSES(MAXP), .GAP(GAPC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .supply_ok(supply_ok),
        .ctl_wr(ctl_wr), .ctl_arm(ctl_arm), .erase_go(erase_go),
        .eng_busy(eng_busy), .eng_glitch(eng_glitch),
        .pgm_start(pgm_start), .pgm_addr(pgm_addr), .pgm_done(pgm_done), .pgm_fail(pgm_fail),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .done(done), .prog_fail(prog_fail), .erase_fail(erase_fail), .supply_fail(supply_fail)
    );

    // Configuration written by the test tasks only
    int  need_cfg [NW];
    int  fail_addr = -1;
    int  glitch_on = 0;
    logic init_req = 1'b0;
    logic log_clr  = 1'b0;

    // Array, program sequencer and erase engine models
    logic [DW-1:0] mem [NW];
    int  need [NW];
    int  pulse_no, ecnt, pcnt_m;
    logic pgm_busy;
    logic [AW-1:0] pgm_a;

    function automatic int widx(input logic [AW-1:0] a);
        return (int'(a) - START) / 2;
    endfunction

    always_comb begin
        if (int'(rd_addr) >= START && int'(rd_addr) < START + BYTES)
            rd_data = mem[widx(rd_addr)];
        else
            rd_data = '0;
    end

    always @(posedge clk) begin
        if (init_req) begin
            for (int i = 0; i < NW; i++) begin
                mem[i]  <= DW'(16'h1234 + i);
                need[i] <= need_cfg[i];
            end
            pulse_no   <= 0;
            ecnt       <= 0;
            pcnt_m     <= 0;
            eng_busy   <= 1'b0;
            eng_glitch <= 1'b0;
            pgm_done   <= 1'b0;
            pgm_fail   <= 1'b0;
            pgm_busy   <= 1'b0;
            pgm_a      <= '0;
        end else begin
            pgm_done <= 1'b0;
            pgm_fail <= 1'b0;
            if (pgm_start) begin
                pgm_busy <= 1'b1;
                pcnt_m   <= 2;
                pgm_a    <= pgm_addr;
            end else if (pgm_busy) begin
                if (pcnt_m == 0) begin
                    pgm_busy <= 1'b0;
                    pgm_done <= 1'b1;
                    if (int'(pgm_a) == fail_addr) pgm_fail <= 1'b1;
                    else mem[widx(pgm_a)] <= '0;
                end else begin
                    pcnt_m <= pcnt_m - 1;
                end
            end
            if (erase_go) begin
                eng_busy   <= 1'b1;
                ecnt       <= 3;
                pulse_no   <= pulse_no + 1;
                eng_glitch <= 1'b0;
            end else if (eng_busy) begin
                if (ecnt == 0) begin
                    eng_busy   <= 1'b0;
                    eng_glitch <= (pulse_no == glitch_on);
                    for (int i = 0; i < NW; i++) begin
                        if (need[i] <= 1) begin
                            need[i] <= 0;
                            mem[i]  <= '1;
                        end else begin
                            need[i] <= need[i] - 1;
                            mem[i]  <= DW'(16'h00F0);
                        end
                    end
                end else begin
                    ecnt <= ecnt - 1;
                end
            end
        end
    end

    // Activity log
    int cyc = 0;
    int pgm_cnt, ctl_cnt, go_cnt, rd_cnt, rd0_cnt, pgm_at_go, prev_cyc;
    logic last_arm, order_bad, pair_bad;
    logic [AW-1:0] prev_addr;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (log_clr) begin
            pgm_cnt <= 0; ctl_cnt <= 0; go_cnt <= 0; rd_cnt <= 0; rd0_cnt <= 0;
            pgm_at_go <= -1; prev_cyc <= 0; last_arm <= 1'b0;
            order_bad <= 1'b0; pair_bad <= 1'b0; prev_addr <= '0;
        end else begin
            if (pgm_start) begin
                if (int'(pgm_addr) != START + 2 * pgm_cnt) order_bad <= 1'b1;
                pgm_cnt <= pgm_cnt + 1;
            end
            if (ctl_wr) begin
                ctl_cnt  <= ctl_cnt + 1;
                last_arm <= ctl_arm;
            end
            if (erase_go) begin
                if (go_cnt == 0) pgm_at_go <= pgm_cnt;
                go_cnt <= go_cnt + 1;
            end
            if (rd_en) begin
                rd_cnt <= rd_cnt + 1;
                if (int'(rd_addr) == START) rd0_cnt <= rd0_cnt + 1;
                if (rd_cnt % 2 == 1) begin
                    if (rd_addr != prev_addr || cyc - prev_cyc < GAPC + 1) pair_bad <= 1'b1;
                end
                prev_addr <= rd_addr;
                prev_cyc  <= cyc;
            end
        end
    end

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic prepare(input int need_all, input int sel, input int sel_need,
                           input int f_addr, input int g_on, input logic sup);
        @(negedge clk);
        for (int i = 0; i < NW; i++) need_cfg[i] = (i == sel) ? sel_need : need_all;
        fail_addr = f_addr;
        glitch_on = g_on;
        supply_ok = sup;
        init_req  = 1'b1;
        log_clr   = 1'b1;
        @(negedge clk);
        init_req  = 1'b0;
        log_clr   = 1'b0;
    endtask

    task automatic run_once();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        while (!done) @(negedge clk);
    endtask

    task automatic t_reset();
        check(!done && !prog_fail && !erase_fail && !supply_fail, "R10 reset flags", int'(done), 0);
        check(!ctl_wr && !erase_go && !pgm_start && !rd_en, "R4 reset strobes", int'(ctl_wr), 0);
    endtask

    task automatic t_resume();
        prepare(1, 2, 2, -1, 0, 1'b1);
        run_once();
        check(done && !prog_fail && !erase_fail && !supply_fail, "R8 success flags",
              int'({prog_fail, erase_fail, supply_fail}), 0);
        check(order_bad == 1'b0 && pgm_cnt == NW, "R1 zero writes", pgm_cnt, NW);
        check(pgm_at_go == NW, "R1 preprogram before pulse", pgm_at_go, NW);
        check(go_cnt == 2, "R7 pulses", go_cnt, 2);
        check(rd_cnt == 18, "R7 reads", rd_cnt, 18);
        check(rd0_cnt == 2, "R7 no rewind to block start", rd0_cnt, 2);
        check(pair_bad == 1'b0, "R6 read pairs and gap", int'(pair_bad), 0);
        check(ctl_cnt == 2 && last_arm == 1'b0, "R8 disarm", ctl_cnt, 2);
        check(ctl_cnt == 2, "R4 single arm write", ctl_cnt, 2);
        for (int i = 0; i < NW; i++)
            check(mem[i] == '1, "R8 block erased", int'(mem[i]), 'hFFFF);
        repeat (10) @(negedge clk);
        check(done && !prog_fail && !erase_fail && !supply_fail, "R10 result held", int'(done), 1);
    endtask

    task automatic t_pgm_fail();
        prepare(1, 0, 1, START + 6, 0, 1'b1);
        run_once();
        check(prog_fail && !erase_fail && !supply_fail, "R2 program fail flag", int'(prog_fail), 1);
        check(pgm_cnt == 4, "R2 abort after failing word", pgm_cnt, 4);
        check(ctl_cnt == 0 && go_cnt == 0, "R2 no erase activity", ctl_cnt + go_cnt, 0);
    endtask

    task automatic t_supply_low();
        prepare(1, 0, 1, -1, 0, 1'b0);
        run_once();
        check(supply_fail && !prog_fail && !erase_fail, "R3 supply fail flag", int'(supply_fail), 1);
        check(pgm_cnt == NW, "R3 preprogram completed", pgm_cnt, NW);
        check(ctl_cnt == 0 && go_cnt == 0, "R3 no arm no pulse", ctl_cnt + go_cnt, 0);
        supply_ok = 1'b1;
    endtask

    task automatic t_glitch();
        prepare(1, 0, 1, -1, 1, 1'b1);
        run_once();
        check(supply_fail && !erase_fail && !prog_fail, "R5 glitch flag", int'(supply_fail), 1);
        check(go_cnt == 1, "R5 single pulse", go_cnt, 1);
        check(rd_cnt == 0, "R5 no verify after glitch", rd_cnt, 0);
        check(ctl_cnt == 2 && last_arm == 1'b0, "R5 disarm after glitch", ctl_cnt, 2);
    endtask

    task automatic t_limit_fail();
        prepare(1, 5, 10, -1, 0, 1'b1);
        run_once();
        check(erase_fail && !supply_fail && !prog_fail, "R9 erase fail flag", int'(erase_fail), 1);
        check(go_cnt == MAXP, "R9 pulse budget", go_cnt, MAXP);
        check(ctl_cnt == 2 && last_arm == 1'b0, "R9 disarm on fail", ctl_cnt, 2);
    endtask

    task automatic t_limit_exact();
        prepare(1, NW - 1, MAXP, -1, 0, 1'b1);
        run_once();
        check(done && !erase_fail, "R9 exact budget succeeds", int'(erase_fail), 0);
        check(go_cnt == MAXP, "R9 exact pulses", go_cnt, MAXP);
    endtask

    task automatic t_restart_ignored();
        prepare(1, 0, 1, -1, 0, 1'b1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (12) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        check(pgm_cnt == NW && order_bad == 1'b0, "R10 start during run ignored", pgm_cnt, NW);
        check(go_cnt == 1 && done && !erase_fail, "R10 single run result", go_cnt, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_resume();
        t_pgm_fail();
        t_supply_low();
        t_glitch();
        t_limit_fail();
        t_limit_exact();
        t_restart_ignored();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule